// File: doc/BRIEF.md
# Integer Width Conversion Unit

This unit turns an integer operand of one width and signedness into an integer of another width and signedness. It takes one 32-bit source word and a set of control fields. It picks a byte-aligned field out of the word and widens that field to 32 bits. It can then apply absolute value and negation. Last, it either clamps the value to the range of the destination type or masks it down to the destination width.

The result goes into a single output register, together with a zero flag, a sign flag and an error flag. A valid/ready handshake controls the transfer, so each result appears one cycle after its operand is accepted. A downstream stall holds the current result and refuses new operands until that result is taken.

Top module: `int_width_conv`

## Requirements
- R1: The size codes are 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. The source field starts at bit `lane_sel`×8 and is as wide as `src_size`. It is sign-extended to 32 bits when `src_signed` is 1 and zero-extended otherwise.
- R2: Some operands are illegal: a 16-bit source with an odd `lane_sel`, a 32-bit source with a nonzero `lane_sel`, or a size code of 3 on either side. An illegal operand gives `out_err` = 1 and `out_word` = 0. A legal operand gives `out_err` = 0.
- R3: After extraction, `take_abs` replaces a negative signed value with its magnitude. Then `take_neg` forms the two's-complement negative. Both work modulo 2^32.
- R4: With `saturate` = 0, a destination narrower than 32 bits gets the value masked to its width. A 32-bit destination gets the value unchanged.
- R5: Saturating from a signed source to an unsigned destination works in two steps. First, a value whose unsigned 32-bit reading is at least 2^(source bits−1) becomes 0. Then, for a destination narrower than 32 bits, the value is limited above to 2^(dest bits)−1.
- R6: Saturating to a signed n-bit destination from an unsigned source, or from a signed source, limits the value to the range −2^(n−1) to 2^(n−1)−1. The result is returned as a 32-bit two's-complement value.
- R7: Saturating from an unsigned source to an unsigned n-bit destination limits the value to 0 to 2^n−1. For a 32-bit destination this bound is all ones, so the value passes unchanged.
- R8: Saturating a 32-bit source to a 32-bit destination of the same signedness leaves the value unchanged. Saturating from an unsigned 32-bit source to a signed 32-bit destination limits the value to 2^31−1.
- R9: When `set_flags` = 1 on an accepted operand, `out_zero` shows whether the result is zero and `out_sign` copies bit 31 of the result. When `set_flags` = 0, both flags keep their previous values.
- R10: `in_ready` is high when the output register is empty or is being read. An accepted operand raises `out_valid` on the next cycle. While `out_valid` = 1 and `out_ready` = 0, the outputs hold still and no operand is accepted.
- R11: After reset, `out_valid`, `out_word`, `out_zero`, `out_sign` and `out_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be accepted |
| src_word | input | 32 | Source word |
| src_size | input | 2 | Source width code |
| dst_size | input | 2 | Destination width code |
| src_signed | input | 1 | Source is signed |
| dst_signed | input | 1 | Destination is signed |
| lane_sel | input | 2 | Byte lane where the source field starts |
| take_abs | input | 1 | Apply absolute value |
| take_neg | input | 1 | Apply negation |
| saturate | input | 1 | Clamp instead of mask |
| set_flags | input | 1 | Update zero and sign flags |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result is being taken |
| out_word | output | 32 | Converted result |
| out_zero | output | 1 | Result was zero |
| out_sign | output | 1 | Bit 31 of result |
| out_err | output | 1 | Illegal selector or size |

## Verification
Byte and halfword fields are taken from several lanes, each with both signedness settings. These cases separate the lane offset from the extension rule. The abs and negate cases use values whose sign differs before and after each step, so the order of the two operations shows in the result. The saturation cases sit on each side of every clamp bound, including the magnitude 2^15 that comes out of abs on a signed halfword, and they cover each of the three word-to-word signedness pairings. Stall and flag-hold sequences show that the output and the flags change only when an operand is accepted with the matching control bits.

// File: rtl/int_width_conv.sv
module int_width_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] src_word,
  input  logic [1:0]  src_size,
  input  logic [1:0]  dst_size,
  input  logic        src_signed,
  input  logic        dst_signed,
  input  logic [1:0]  lane_sel,
  input  logic        take_abs,
  input  logic        take_neg,
  input  logic        saturate,
  input  logic        set_flags,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_word,
  output logic        out_zero,
  output logic        out_sign,
  output logic        out_err
);

  logic [31:0] shf, fmask, dmask, ext, av, res;
  logic [32:0] x, lo, hi;
  logic [5:0]  sb, db;
  logic        sgn, bad;

  assign in_ready = !out_valid || out_ready;
  wire accept = in_valid && in_ready;

  assign bad = (src_size == 2'd3) || (dst_size == 2'd3) ||
               (src_size == 2'd1 && lane_sel[0]) ||
               (src_size == 2'd2 && lane_sel != 2'd0);

  always_comb begin
    sb = (src_size == 2'd0) ? 6'd8 : (src_size == 2'd1) ? 6'd16 : 6'd32;
    db = (dst_size == 2'd0) ? 6'd8 : (dst_size == 2'd1) ? 6'd16 : 6'd32;
    shf = src_word >> {lane_sel, 3'b000};
    fmask = (sb == 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << sb) - 32'd1);
    dmask = (db == 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << db) - 32'd1);
    case (src_size)
      2'd0:    sgn = src_signed && shf[7];
      2'd1:    sgn = src_signed && shf[15];
      default: sgn = src_signed && shf[31];
    endcase
    ext = (shf & fmask) | (sgn ? ~fmask : 32'd0);
    av = ext;
    if (take_abs && src_signed && av[31]) av = 32'd0 - av;
    if (take_neg) av = 32'd0 - av;
    x  = {src_signed && av[31], av};
    lo = 33'd0;
    hi = {1'b0, dmask};
    if (!saturate) begin
      res = av & dmask;
    end else if (src_signed && !dst_signed) begin
      res = (av >= (32'd1 << (sb - 6'd1))) ? 32'd0 : av;
      if (db != 6'd32 && res > dmask) res = dmask;
    end else begin
      if (dst_signed) begin
        lo = 33'd0 - (33'd1 << (db - 6'd1));
        hi = (33'd1 << (db - 6'd1)) - 33'd1;
      end
      if ($signed(x) < $signed(lo))      x = lo;
      else if ($signed(x) > $signed(hi)) x = hi;
      res = x[31:0];
    end
    if (bad) res = 32'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= 32'd0;
      out_zero  <= 1'b0;
      out_sign  <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_word  <= res;
        out_err   <= bad;
        if (set_flags) begin
          out_zero <= (res == 32'd0);
          out_sign <= res[31];
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r10_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_err)));
  a_r2_err_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_word == 32'd0));
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !set_flags) |=> ($stable(out_zero) && $stable(out_sign)));
  a_r9_sign_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && set_flags) |=> (out_sign == out_word[31] && out_zero == (out_word == 32'd0)));

endmodule

// File: tb/test_int_width_conv.sv
module test_int_width_conv;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [31:0] src_word = '0, out_word;
  logic [1:0] src_size = '0, dst_size = '0, lane_sel = '0;
  logic src_signed = 0, dst_signed = 0, take_abs = 0, take_neg = 0, saturate = 0, set_flags = 0;
  logic out_zero, out_sign, out_err;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_width_conv i_int_width_conv (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [31:0] w, input logic [1:0] ss, input logic [1:0] ds,
                    input bit ssg, input bit dsg, input logic [1:0] sel, input bit ab,
                    input bit ng, input bit sat, input bit fl);
    src_word = w; src_size = ss; dst_size = ds; src_signed = ssg; dst_signed = dsg;
    lane_sel = sel; take_abs = ab; take_neg = ng; saturate = sat; set_flags = fl;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic conv(input string req, input logic [31:0] w, input logic [1:0] ss,
                      input logic [1:0] ds, input bit ssg, input bit dsg, input logic [1:0] sel,
                      input bit ab, input bit ng, input bit sat, input logic [31:0] exp);
    op(w, ss, ds, ssg, dsg, sel, ab, ng, sat, 1'b0);
    check(req, out_word, exp);
    check({req, " err"}, {31'd0, out_err}, 32'd0);
  endtask

  task automatic t_reset();
    check("R11 valid", {31'd0, out_valid}, 32'd0);
    check("R11 word", out_word, 32'd0);
    check("R11 flags", {29'd0, out_zero, out_sign, out_err}, 32'd0);
  endtask

  task automatic t_extract();
    conv("R1 byte lane2 signed", 32'h0080_0000, 0, 2, 1, 1, 2, 0, 0, 0, 32'hFFFF_FF80);
    conv("R1 byte lane2 unsigned", 32'h0080_0000, 0, 2, 0, 0, 2, 0, 0, 0, 32'h0000_0080);
    conv("R1 byte lane3 signed", 32'h7F00_0000, 0, 2, 1, 1, 3, 0, 0, 0, 32'h0000_007F);
    conv("R1 short lane2 signed", 32'h9234_ABCD, 1, 2, 1, 1, 2, 0, 0, 0, 32'hFFFF_9234);
    conv("R1 short lane0 unsigned", 32'h9234_ABCD, 1, 2, 0, 0, 0, 0, 0, 0, 32'h0000_ABCD);
  endtask

  task automatic t_absneg();
    conv("R3 abs", 32'h0000_00F0, 0, 2, 1, 1, 0, 1, 0, 0, 32'h0000_0010);
    conv("R3 neg unsigned", 32'h0000_0005, 0, 2, 0, 0, 0, 0, 1, 0, 32'hFFFF_FFFB);
    conv("R3 abs then neg", 32'h0000_00F0, 0, 2, 1, 1, 0, 1, 1, 0, 32'hFFFF_FFF0);
    conv("R3 abs on unsigned", 32'h0000_00F0, 0, 2, 0, 0, 0, 1, 0, 0, 32'h0000_00F0);
  endtask

  task automatic t_mask();
    conv("R4 mask byte", 32'h1234_ABCD, 1, 0, 1, 0, 2, 0, 0, 0, 32'h0000_0034);
    conv("R4 mask short", 32'h0000_0080, 0, 1, 1, 1, 0, 0, 0, 0, 32'h0000_FF80);
  endtask

  task automatic t_sat();
    conv("R5 negative to zero", 32'h0000_0090, 0, 0, 1, 0, 0, 0, 0, 1, 32'd0);
    conv("R5 upper clamp", 32'h0000_7FFF, 1, 0, 1, 0, 0, 0, 0, 1, 32'h0000_00FF);
    conv("R5 abs min short", 32'h0000_8000, 1, 2, 1, 0, 0, 1, 0, 1, 32'd0);
    conv("R5 in range", 32'h0000_0042, 0, 0, 1, 0, 0, 0, 0, 1, 32'h0000_0042);
    conv("R6 high", 32'd300, 2, 0, 1, 1, 0, 0, 0, 1, 32'd127);
    conv("R6 low", 32'hFFFF_FED4, 2, 0, 1, 1, 0, 0, 0, 1, 32'hFFFF_FF80);
    conv("R6 unsigned src", 32'h0000_0090, 0, 0, 0, 1, 0, 0, 0, 1, 32'd127);
    conv("R6 inside", 32'hFFFF_FF85, 2, 0, 1, 1, 0, 0, 0, 1, 32'hFFFF_FF85);
    conv("R7 short", 32'h0001_2345, 2, 1, 0, 0, 0, 0, 0, 1, 32'h0000_FFFF);
    conv("R7 word", 32'hFFFF_FFFF, 2, 2, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    conv("R8 u to s", 32'h8000_0000, 2, 2, 0, 1, 0, 0, 0, 1, 32'h7FFF_FFFF);
    conv("R8 s to s", 32'h8000_0000, 2, 2, 1, 1, 0, 0, 0, 1, 32'h8000_0000);
    conv("R8 s to u", 32'h8000_0000, 2, 2, 1, 0, 0, 0, 0, 1, 32'd0);
  endtask

  task automatic t_err();
    op(32'h1234_5678, 1, 2, 0, 0, 1, 0, 0, 0, 1'b1);
    check("R2 short odd lane word", out_word, 32'd0);
    check("R2 short odd lane err", {31'd0, out_err}, 32'd1);
    check("R9 zero flag on error", {31'd0, out_zero}, 32'd1);
    op(32'h1234_5678, 2, 2, 0, 0, 2, 0, 0, 0, 1'b0);
    check("R2 word lane2 err", {31'd0, out_err}, 32'd1);
    op(32'h1234_5678, 3, 2, 0, 0, 0, 0, 0, 0, 1'b0);
    check("R2 long source err", {31'd0, out_err}, 32'd1);
    op(32'h1234_5678, 1, 2, 0, 0, 2, 0, 0, 0, 1'b0);
    check("R2 short lane2 legal", {31'd0, out_err}, 32'd0);
  endtask

  task automatic t_flags();
    op(32'h0000_0080, 0, 2, 1, 1, 0, 0, 0, 0, 1'b1);
    check("R9 sign set", {30'd0, out_zero, out_sign}, 32'd1);
    op(32'h0000_0000, 0, 2, 0, 0, 0, 0, 0, 0, 1'b0);
    check("R9 held without request", {30'd0, out_zero, out_sign}, 32'd1);
    check("R9 word still updates", out_word, 32'd0);
    op(32'h0000_0000, 0, 2, 0, 0, 0, 0, 0, 0, 1'b1);
    check("R9 zero set", {30'd0, out_zero, out_sign}, 32'd2);
  endtask

  task automatic t_stall();
    op(32'h0000_0011, 0, 2, 0, 0, 0, 0, 0, 0, 1'b0);
    check("R10 valid after accept", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b0;
    src_word = 32'h0000_0022; in_valid = 1'b1;
    @(negedge clk);
    check("R10 not ready in stall", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    check("R10 word held", out_word, 32'h0000_0011);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 accepted after release", out_word, 32'h0000_0022);
    @(negedge clk);
    check("R10 valid drops", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_extract();
    t_absneg();
    t_mask();
    t_sat();
    t_err();
    t_flags();
    t_stall();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule